// File: doc/BRIEF.md
# Fault Response Retry Controller

This block decides how a power sequencer reacts to an input or output voltage fault. Each fault source has a two-bit response code of its own. Code 00 lets operation continue as if nothing had happened. Code 10 orders a power-down of all rails in reverse order. When all rails are down, a retry policy shared by every source decides between a restart and a lock-off.

The shared retry field is 3 bits wide. Value 0 means never restart, values 1 to 6 allow that many restarts, and value 7 allows any number. A shared 3-bit delay field also applies to every source. Value 0 asks for the restart as soon as every power-good signal has dropped. Any value from 1 to 7 inserts one fixed wait of `DELAY_CYC` clock cycles. The restart count and the lock-off are cleared only by driving the enable input low. Rail sequencing and the voltage comparison are handled by neighbouring blocks.

Top module: `fault_retry_ctrl`

## Requirements
- R1: After reset, `pwr_down_req`, `seq_up_req`, `latched_off` and `bad_data` are 0, and every source's response code is 00.
- R2: A fault pulse on a source whose response code is 00 (continue) has no effect. `pwr_down_req` stays 0.
- R3: While enabled and running, a fault pulse on a source whose response code is 10 (shut down) raises `pwr_down_req` in the next cycle. It stays high until `all_pg_low` is seen.
- R4: A response write with code 01 or 11 is rejected, and the source keeps its previous code. `bad_data` is high for the one cycle after the write. Valid codes 00 and 10 are stored in the cycle after the write and raise no flag.
- R5: With retry field 0, the shutdown ends in `latched_off`=1 once `all_pg_low` is seen, and no `seq_up_req` is issued.
- R6: With a retry field n from 1 to 6, exactly n restarts are issued after successive shutdowns. The shutdown after those ends in `latched_off`.
- R7: With retry field 7, every shutdown is followed by a restart, with no limit.
- R8: With delay field 0, `seq_up_req` is high for exactly one cycle, starting in the cycle after the one in which `all_pg_low` is sampled during a shutdown.
- R9: With a delay field from 1 to 7, `seq_up_req` rises `DELAY_CYC`+1 cycles after `all_pg_low` is sampled, and it lasts one cycle.
- R10: A fault that arrives while a power-down is already in progress is absorbed and does not use up a retry.
- R11: Driving `enable` low clears `latched_off`, any pending request and the restart count. When `enable` is driven high again, the full retry allowance is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer enable. Low clears the retry state |
| fault_pulse | input | N_SRC | One pulse per fault source |
| resp_wr | input | 1 | Response code write strobe |
| resp_sel | input | SEL_W | Source whose response code is written |
| resp_code | input | 2 | Response code to write (00 continue, 10 shut down) |
| retry_field | input | 3 | Shared retry policy |
| delay_field | input | 3 | Shared restart delay select |
| all_pg_low | input | 1 | Every rail's power-good has deasserted |
| pwr_down_req | output | 1 | Request a reverse-order power-down |
| seq_up_req | output | 1 | One-cycle request to sequence the rails back up |
| latched_off | output | 1 | Retries exhausted, held off until enable goes low |
| bad_data | output | 1 | One-cycle flag for a rejected response code |

## Verification
A wrong restart count shows up at the ports as one restart too many or too few before `latched_off` rises, and it only shows in the shutdown where the allowance runs out. A fault that is not absorbed during a power-down is caught by the next shutdown, which then locks off early. A corrupted response register shows as a fault that is ignored when it should not be, or the reverse, in the cycle after the fault pulse. A timer that is off by one moves the `seq_up_req` edge by a cycle, and this is visible on the first delayed restart.

// File: rtl/fault_retry_pkg.sv
package fault_retry_pkg;
    localparam logic [1:0] RESP_CONT = 2'b00;
    localparam logic [1:0] RESP_SHUT = 2'b10;
    localparam logic [2:0] RETRY_NONE = 3'd0;
    localparam logic [2:0] RETRY_INF  = 3'd7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_SHUT,
        ST_WAIT,
        ST_KICK,
        ST_LOCK
    } ctrl_state_e;
endpackage

// File: rtl/resp_bank.sv
module resp_bank #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       code,
    output logic [N_SRC-1:0] shut_mask,
    output logic             bad_code
);
    import fault_retry_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0][1:0] resp;
        logic                  bad;
    } bank_t;

    bank_t b_d, b_q;
    logic  valid_code;

    always_comb begin
        b_d        = b_q;
        b_d.bad    = 1'b0;
        valid_code = (code == RESP_CONT) || (code == RESP_SHUT);
        if (wr) begin
            if (!valid_code) begin
                b_d.bad = 1'b1;
            end else if (int'(sel) < N_SRC) begin
                b_d.resp[sel] = code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        assign shut_mask[i] = (b_q.resp[i] == RESP_SHUT);
    end

    assign bad_code = b_q.bad;
endmodule

// File: rtl/restart_timer.sv
module restart_timer #(
    parameter int DELAY_CYC = 1000,
    parameter int CNT_W     = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic expired
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYC - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (abort) begin
            t_d.active = 1'b0;
        end else if (start) begin
            t_d.active = 1'b1;
            t_d.cnt    = LOAD;
        end else if (t_q.active) begin
            if (t_q.cnt == '0) begin
                t_d.active = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = t_q.active && (t_q.cnt == '0);
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
    parameter int N_SRC     = 4,
    parameter int DELAY_CYC = 1000,
    parameter int SEL_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [N_SRC-1:0] fault_pulse,
    input  logic             resp_wr,
    input  logic [SEL_W-1:0] resp_sel,
    input  logic [1:0]       resp_code,
    input  logic [2:0]       retry_field,
    input  logic [2:0]       delay_field,
    input  logic             all_pg_low,
    output logic             pwr_down_req,
    output logic             seq_up_req,
    output logic             latched_off,
    output logic             bad_data
);
    import fault_retry_pkg::*;

    typedef struct packed {
        ctrl_state_e st;
        logic [2:0]  tries;
    } ctrl_t;

    ctrl_t            c_d, c_q;
    logic [N_SRC-1:0] shut_mask;
    logic             shut_hit;
    logic             tmr_start;
    logic             tmr_done;
    ctrl_state_e      resume_st;

    resp_bank #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (resp_wr),
        .sel       (resp_sel),
        .code      (resp_code),
        .shut_mask (shut_mask),
        .bad_code  (bad_data)
    );

    restart_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .abort   (!enable),
        .expired (tmr_done)
    );

    assign shut_hit  = |(fault_pulse & shut_mask);
    assign resume_st = (delay_field == 3'd0) ? ST_KICK : ST_WAIT;

    always_comb begin
        c_d       = c_q;
        tmr_start = 1'b0;
        if (!enable) begin
            c_d.st    = ST_OFF;
            c_d.tries = '0;
        end else begin
            case (c_q.st)
                ST_OFF:  c_d.st = ST_RUN;
                ST_RUN:  if (shut_hit) c_d.st = ST_SHUT;
                ST_SHUT: begin
                    if (all_pg_low) begin
                        if (retry_field == RETRY_NONE) begin
                            c_d.st = ST_LOCK;
                        end else if (retry_field == RETRY_INF) begin
                            c_d.st = resume_st;
                        end else if (c_q.tries < retry_field) begin
                            c_d.tries = c_q.tries + 1'b1;
                            c_d.st    = resume_st;
                        end else begin
                            c_d.st = ST_LOCK;
                        end
                        tmr_start = (c_d.st == ST_WAIT);
                    end
                end
                ST_WAIT: if (tmr_done) c_d.st = ST_KICK;
                ST_KICK: c_d.st = ST_RUN;
                ST_LOCK: c_d.st = ST_LOCK;
                default: c_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_OFF, tries: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign pwr_down_req = (c_q.st == ST_SHUT);
    assign seq_up_req   = (c_q.st == ST_KICK);
    assign latched_off  = (c_q.st == ST_LOCK);
endmodule

// File: rtl/fault_retry_ctrl_chk.sv
module fault_retry_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       all_pg_low,
    input logic       resp_wr,
    input logic [1:0] resp_code,
    input logic       pwr_down_req,
    input logic       seq_up_req,
    input logic       latched_off,
    input logic       bad_data
);
    assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down_req && seq_up_req));

    assert_hold_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_req && !all_pg_low && enable) |=> pwr_down_req);

    assert_bad_code_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_wr && resp_code[0]) |=> bad_data);

    assert_good_code_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_wr && !resp_code[0]) |=> !bad_data);

    assert_seq_up_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_up_req |=> !seq_up_req);

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && enable) |=> latched_off);

    assert_enable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!latched_off && !pwr_down_req && !seq_up_req));
endmodule

bind fault_retry_ctrl fault_retry_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .all_pg_low   (all_pg_low),
    .resp_wr      (resp_wr),
    .resp_code    (resp_code),
    .pwr_down_req (pwr_down_req),
    .seq_up_req   (seq_up_req),
    .latched_off  (latched_off),
    .bad_data     (bad_data)
);

// File: tb/fault_retry_ctrl_tb.sv
module fault_retry_ctrl_tb;
    localparam int N_SRC = 4;
    localparam int DLY   = 6;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [N_SRC-1:0] fault_pulse = '0;
    logic             resp_wr = 1'b0;
    logic [SEL_W-1:0] resp_sel = '0;
    logic [1:0]       resp_code = '0;
    logic [2:0]       retry_field = '0;
    logic [2:0]       delay_field = '0;
    logic             all_pg_low = 1'b0;
    logic             pwr_down_req, seq_up_req, latched_off, bad_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_retry_ctrl #(.N_SRC(N_SRC), .DELAY_CYC(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fault_pulse(fault_pulse),
        .resp_wr(resp_wr), .resp_sel(resp_sel), .resp_code(resp_code),
        .retry_field(retry_field), .delay_field(delay_field),
        .all_pg_low(all_pg_low), .pwr_down_req(pwr_down_req),
        .seq_up_req(seq_up_req), .latched_off(latched_off), .bad_data(bad_data)
    );

    function automatic int exp_wait(input logic [2:0] dly);
        return (dly == 3'd0) ? 1 : DLY + 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_resp(input int src, input logic [1:0] code);
        resp_wr = 1'b1; resp_sel = SEL_W'(src); resp_code = code;
        tick();
        resp_wr = 1'b0;
    endtask

    task automatic pulse(input int src);
        fault_pulse[src] = 1'b1;
        tick();
        fault_pulse = '0;
    endtask

    task automatic re_enable();
        enable = 1'b0; tick();
        enable = 1'b1; tick();
    endtask

    // One shutdown: fault on src 0, then rails drop. Reports restart and wait.
    task automatic shut_cycle(output bit restarted, output int waited, input bit extra);
        restarted = 1'b0; waited = 0;
        pulse(0);
        if (extra) begin
            pulse(2);
        end
        all_pg_low = 1'b1;
        for (int k = 1; k <= DLY + 4; k++) begin
            tick();
            all_pg_low = 1'b0;
            if (seq_up_req) begin restarted = 1'b1; waited = k; break; end
            if (latched_off) break;
        end
        all_pg_low = 1'b0;
        tick();
    endtask

    initial begin
        bit r;
        int w;
        int cnt;
        void'($urandom(32'h5eed_1234));
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 pwr_down", int'(pwr_down_req), 0);
        check("R1 seq_up", int'(seq_up_req), 0);
        check("R1 latched", int'(latched_off), 0);
        check("R1 bad_data", int'(bad_data), 0);
        enable = 1'b1; tick(); tick();
        pulse(0);
        check("R1 default code 00 ignores fault", int'(pwr_down_req), 0);

        // R4 valid and invalid writes
        write_resp(0, 2'b10);
        check("R4 valid write no flag", int'(bad_data), 0);
        write_resp(1, 2'b01);
        check("R4 code 01 flagged", int'(bad_data), 1);
        tick();
        check("R4 flag one cycle", int'(bad_data), 0);
        write_resp(0, 2'b11);
        check("R4 code 11 flagged", int'(bad_data), 1);
        write_resp(2, 2'b10);

        // R2 source 1 stays continue (01 write rejected)
        pulse(1);
        check("R2 ignored fault", int'(pwr_down_req), 0);
        tick();
        check("R2 still running", int'(pwr_down_req), 0);

        // R3 / R4 source 0 kept code 10 despite 11 write
        retry_field = 3'd7; delay_field = 3'd0;
        pulse(0);
        check("R3 R4 power-down raised", int'(pwr_down_req), 1);
        tick(); tick();
        check("R3 power-down held", int'(pwr_down_req), 1);
        all_pg_low = 1'b1; tick(); all_pg_low = 1'b0;
        check("R8 restart next cycle", int'(seq_up_req), 1);
        tick();
        check("R8 restart one cycle", int'(seq_up_req), 0);

        // R5 no retry
        retry_field = 3'd0;
        shut_cycle(r, w, 1'b0);
        check("R5 no restart", int'(r), 0);
        check("R5 latched", int'(latched_off), 1);
        pulse(0);
        check("R5 stays latched", int'(latched_off), 1);

        // R11 enable low clears lock
        enable = 1'b0; tick();
        check("R11 lock cleared", int'(latched_off), 0);
        enable = 1'b1; tick();

        // R10 absorb fault during power-down, retry 1
        retry_field = 3'd1;
        shut_cycle(r, w, 1'b1);
        check("R10 first restart", int'(r), 1);
        shut_cycle(r, w, 1'b0);
        check("R10 second shutdown locks", int'(latched_off), 1);

        // R11 count cleared by enable low
        re_enable();
        shut_cycle(r, w, 1'b0);
        check("R11 allowance restored", int'(r), 1);

        // R9 delayed restart
        re_enable();
        retry_field = 3'd7; delay_field = 3'd3;
        shut_cycle(r, w, 1'b0);
        check("R9 delayed restart", w, exp_wait(3'd3));

        // R7 unlimited
        delay_field = 3'd0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            shut_cycle(r, w, 1'b0);
            cnt += int'(r);
        end
        check("R7 unlimited restarts", cnt, 10);

        // R6 R9 random bounded retries and delays
        for (int it = 0; it < 8; it++) begin
            logic [2:0] code;
            logic [2:0] dly;
            code = 3'($urandom_range(6, 1));
            dly  = 3'($urandom_range(7, 0));
            retry_field = code; delay_field = dly;
            re_enable();
            cnt = 0;
            for (int j = 0; j < 9; j++) begin
                shut_cycle(r, w, bit'($urandom_range(1, 0)));
                if (r) begin
                    cnt++;
                    check("R9 restart timing", w, exp_wait(dly));
                end
                if (latched_off) break;
            end
            check("R6 bounded restarts", cnt, int'(code));
            check("R6 latched after allowance", int'(latched_off), 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule